// File: doc/BRIEF.md
# Indirect Jump Target Predictor

This block supplies a predicted destination address for indirect jumps, whose target can be any of many addresses rather than one of two. A fetch stage presents the jump's instruction address on the lookup port. In the same cycle the block answers with a hit flag and a full target address. Each entry stores a complete address, so one jump site can be predicted to land in different places depending on the path that led to it.

Prediction works on two levels. A path history register is built from two bits of every resolved indirect target. The history is XOR-ed with word-address bits of the instruction address to select an entry in a path table. When that entry is absent or belongs to another jump, the block falls back to a second table. That table is indexed by address alone and holds the target the same jump took most recently. When both tables miss, the block predicts the next sequential word.

A resolved indirect jump trains both tables and advances the history. A software preload command installs a fallback entry with a target formed as a base register value plus a sign-extended displacement. A preload does not change the history.

Top module: `indirect_target_pred`

## Requirements
- R1: A synchronous reset invalidates every entry of both tables and clears the history to zero. In the first cycle after reset, any lookup returns hit low and target equal to the lookup address plus 4.
- R2: When neither table holds a valid entry with a matching tag for the lookup, `lk_hit` is 0 and `lk_target` is `lk_pc + 4`.
- R3: A resolved update writes the target, a valid bit and the tag `upd_pc[IW+2 +: TW]` into the fallback entry at index `upd_pc[IW+1:2]`. A later lookup of that address that misses the path table returns hit 1 with that target.
- R4: The same update writes the path table entry at index `upd_pc[IW+1:2] XOR hist[IW-1:0]`, where `hist` is the history held before the update, with the same tag and target.
- R5: The path table is consulted first. When its entry at `lk_pc[IW+1:2] XOR hist` is valid and its tag equals `lk_pc[IW+2 +: TW]`, that entry's target is output, even if the fallback entry holds a different target.
- R6: Each update shifts the history left by two bits and inserts `upd_target[3:2]` at bits [1:0]. Nothing else changes the history.
- R7: A lookup whose tag bits differ from the stored tag does not hit, even when the index matches.
- R8: A preload writes only the fallback entry at index `pl_pc[IW+1:2]`, with tag `pl_pc[IW+2 +: TW]` and target `pl_base + sign_extend(pl_disp)`. The path table and the history are unchanged.
- R9: When an update and a preload address the same fallback entry in the same cycle, the update's target is stored.
- R10: Lookups read only registered state. A write in the same cycle as a lookup is seen only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | AW | Address of the indirect jump being fetched |
| lk_hit | output | 1 | A stored prediction was found |
| lk_target | output | AW | Predicted target, or lk_pc+4 on miss |
| upd_valid | input | 1 | A resolved indirect jump is reported this cycle |
| upd_pc | input | AW | Address of the resolved jump |
| upd_target | input | AW | Actual target of the resolved jump |
| pl_valid | input | 1 | Preload command this cycle |
| pl_pc | input | AW | Address of the jump to preload |
| pl_base | input | AW | Base register value |
| pl_disp | input | DW | Signed displacement |

## Verification
A corrupted history register shows up as path table misses or wrong path hits. These appear on the first lookup of a trained address after the fault, so the bench drives the history back to known values and then checks that the path entry wins over a different fallback target. A wrong index, tag or write priority in either table shows on the next lookup of the affected address, one cycle after the write. A bench model, fed the same random and directed traffic, compares hit and target on every cycle. An error that forwards a same-cycle write appears in the same cycle as the write.

// File: rtl/indirect_target_pred.sv
module indirect_target_pred #(
  parameter int AW = 32,
  parameter int IW = 8,
  parameter int HW = 8,
  parameter int TW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output logic [AW-1:0] lk_target,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic [AW-1:0] upd_target,
  input  logic          pl_valid,
  input  logic [AW-1:0] pl_pc,
  input  logic [AW-1:0] pl_base,
  input  logic [DW-1:0] pl_disp
);
  localparam int N = 1 << IW;

  logic [HW-1:0] hist;
  logic [N-1:0]  p_vld, f_vld;
  logic [TW-1:0] p_tag [N];
  logic [TW-1:0] f_tag [N];
  logic [AW-1:0] p_tgt [N];
  logic [AW-1:0] f_tgt [N];

  function automatic logic [IW-1:0] fidx(input logic [AW-1:0] pc);
    return pc[2 +: IW];
  endfunction
  function automatic logic [TW-1:0] tagof(input logic [AW-1:0] pc);
    return pc[IW+2 +: TW];
  endfunction

  wire [IW-1:0] lk_pi = fidx(lk_pc) ^ hist[IW-1:0];
  wire [IW-1:0] lk_fi = fidx(lk_pc);
  wire [IW-1:0] up_pi = fidx(upd_pc) ^ hist[IW-1:0];
  wire [IW-1:0] up_fi = fidx(upd_pc);
  wire [IW-1:0] pl_fi = fidx(pl_pc);
  wire [AW-1:0] pl_val = pl_base + {{(AW-DW){pl_disp[DW-1]}}, pl_disp};
  wire          pl_do = pl_valid && !(upd_valid && up_fi == pl_fi);

  wire p_hit = p_vld[lk_pi] && p_tag[lk_pi] == tagof(lk_pc);
  wire f_hit = f_vld[lk_fi] && f_tag[lk_fi] == tagof(lk_pc);

  assign lk_hit    = p_hit || f_hit;
  assign lk_target = p_hit ? p_tgt[lk_pi] : f_hit ? f_tgt[lk_fi] : lk_pc + AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld <= '0;
      f_vld <= '0;
      hist  <= '0;
    end else begin
      if (pl_do) f_vld[pl_fi] <= 1'b1;
      if (upd_valid) begin
        p_vld[up_pi] <= 1'b1;
        f_vld[up_fi] <= 1'b1;
        hist <= {hist[HW-3:0], upd_target[3:2]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pl_do) begin
      f_tag[pl_fi] <= tagof(pl_pc);
      f_tgt[pl_fi] <= pl_val;
    end
    if (upd_valid) begin
      p_tag[up_pi] <= tagof(upd_pc);
      p_tgt[up_pi] <= upd_target;
      f_tag[up_fi] <= tagof(upd_pc);
      f_tgt[up_fi] <= upd_target;
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  a_r6_hist_shift: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> hist[1:0] == $past(upd_target[3:2]) && hist[HW-1:2] == $past(hist[HW-3:0]));

  a_r8_preload_keeps_hist: assert property (@(posedge clk) disable iff (rst)
    pl_valid && !upd_valid |=> $stable(hist));

  a_r3_update_sets_fallback: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> f_vld[$past(up_fi)] && f_tgt[$past(up_fi)] == $past(upd_target));

  a_r9_update_wins: assert property (@(posedge clk) disable iff (rst)
    upd_valid && pl_valid && up_fi == pl_fi |=> f_tgt[$past(pl_fi)] == $past(upd_target));
endmodule

// File: tb/indirect_target_pred_tb_top.sv
module indirect_target_pred_tb_top;
  localparam int AW = 32, IW = 8, HW = 8, TW = 8, DW = 16;
  localparam int N = 1 << IW;

  logic clk = 0, rst = 1;
  logic [AW-1:0] lk_pc = 0, upd_pc = 0, upd_target = 0, pl_pc = 0, pl_base = 0;
  logic [DW-1:0] pl_disp = 0;
  logic upd_valid = 0, pl_valid = 0, lk_hit;
  logic [AW-1:0] lk_target;

  indirect_target_pred #(.AW(AW), .IW(IW), .HW(HW), .TW(TW), .DW(DW)) dut_i (
    .clk, .rst, .lk_pc, .lk_hit, .lk_target, .upd_valid, .upd_pc, .upd_target,
    .pl_valid, .pl_pc, .pl_base, .pl_disp);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [HW-1:0] m_hist;
  bit            mp_v [N];
  bit            mf_v [N];
  logic [TW-1:0] mp_t [N];
  logic [TW-1:0] mf_t [N];
  logic [AW-1:0] mp_d [N];
  logic [AW-1:0] mf_d [N];

  function automatic logic [IW-1:0] ix(input logic [AW-1:0] pc); return pc[2 +: IW]; endfunction
  function automatic logic [TW-1:0] tg(input logic [AW-1:0] pc); return pc[IW+2 +: TW]; endfunction

  function automatic logic [AW:0] predict(input logic [AW-1:0] pc);
    logic [IW-1:0] pi = ix(pc) ^ m_hist[IW-1:0];
    if (mp_v[pi] && mp_t[pi] == tg(pc)) return {1'b1, mp_d[pi]};
    if (mf_v[ix(pc)] && mf_t[ix(pc)] == tg(pc)) return {1'b1, mf_d[ix(pc)]};
    return {1'b0, pc + 32'd4};
  endfunction

  task automatic model_clear();
    m_hist = '0;
    for (int i = 0; i < N; i++) begin mp_v[i] = 0; mf_v[i] = 0; end
  endtask

  task automatic model_step();
    if (pl_valid && !(upd_valid && ix(upd_pc) == ix(pl_pc))) begin
      mf_v[ix(pl_pc)] = 1; mf_t[ix(pl_pc)] = tg(pl_pc);
      mf_d[ix(pl_pc)] = pl_base + {{(AW-DW){pl_disp[DW-1]}}, pl_disp};
    end
    if (upd_valid) begin
      logic [IW-1:0] pi = ix(upd_pc) ^ m_hist[IW-1:0];
      mp_v[pi] = 1; mp_t[pi] = tg(upd_pc); mp_d[pi] = upd_target;
      mf_v[ix(upd_pc)] = 1; mf_t[ix(upd_pc)] = tg(upd_pc); mf_d[ix(upd_pc)] = upd_target;
      m_hist = {m_hist[HW-3:0], upd_target[3:2]};
    end
  endtask

  task automatic check(input string req);
    logic [AW:0] e = predict(lk_pc);
    checks++;
    if (lk_hit !== e[AW] || lk_target !== e[AW-1:0]) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%0b tgt=%h expected hit=%0b tgt=%h",
               req, lk_pc, lk_hit, lk_target, e[AW], e[AW-1:0]);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] lpc, input bit uv, input logic [AW-1:0] upc,
                     input logic [AW-1:0] ut, input bit pv, input logic [AW-1:0] ppc,
                     input logic [AW-1:0] pb, input logic [DW-1:0] pd, input string req);
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_target = ut;
    pl_valid = pv; pl_pc = ppc; pl_base = pb; pl_disp = pd;
    #1 check(req);
    @(posedge clk);
    model_step();
  endtask

  logic [AW-1:0] pool [8];

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: empty after reset
    cyc(32'h100, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(32'h1000, 0, 0, 0, 0, 0, 0, 0, "R1 R2");
    // R4 R6: train A at two histories
    cyc(32'h1000, 1, 32'h1000, 32'h2004, 0, 0, 0, 0, "R10");
    cyc(32'h1000, 1, 32'h1000, 32'h3008, 0, 0, 0, 0, "R3");
    cyc(32'h1000, 0, 0, 0, 0, 0, 0, 0, "R3");
    for (int k = 0; k < 4; k++) cyc(32'h4440, 1, 32'h4440, 32'h5000, 0, 0, 0, 0, "R6");
    // R5: history back to zero, path entry (0x2004) beats fallback (0x3008)
    cyc(32'h1000, 0, 0, 0, 0, 0, 0, 0, "R5");
    if (lk_target !== 32'h2004) begin errors++; $display("FAIL R5 actual=%h expected=%h", lk_target, 32'h2004); end
    checks++;
    // R7: tag differs, index same
    cyc(32'h1400, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R8 R10: preload with negative displacement, no forwarding
    cyc(32'h8000, 0, 0, 0, 1, 32'h8000, 32'h10000, 16'hFFF0, "R10");
    cyc(32'h8000, 0, 0, 0, 0, 0, 0, 0, "R8");
    if (lk_target !== 32'h0000FFF0) begin errors++; $display("FAIL R8 actual=%h expected=%h", lk_target, 32'h0000FFF0); end
    checks++;
    cyc(32'h1000, 0, 0, 0, 0, 0, 0, 0, "R8 hist kept");
    // R9: collision on fallback entry
    cyc(32'h9000, 1, 32'h9000, 32'hA00C, 1, 32'h9000, 32'h1, 16'h7, "R10");
    cyc(32'h9000, 0, 0, 0, 0, 0, 0, 0, "R9");
    if (lk_target !== 32'hA00C) begin errors++; $display("FAIL R9 actual=%h expected=%h", lk_target, 32'hA00C); end
    checks++;
    // random traffic
    for (int i = 0; i < 8; i++) pool[i] = ($urandom & 32'h0003_FFFC);
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a = ($urandom % 8 == 0) ? ($urandom & ~32'h3) : pool[$urandom % 8];
      logic [AW-1:0] b = pool[$urandom % 8];
      logic [AW-1:0] c = pool[$urandom % 8];
      logic [AW:0] e;
      e = predict(a);
      cyc(a, ($urandom % 10) < 4, b, $urandom & ~32'h3, ($urandom % 10) < 2, c,
          $urandom, 16'($urandom), e[AW] ? "R3 R5" : "R2");
    end
    // R1: reset again clears everything
    @(negedge clk); rst = 1; upd_valid = 0; pl_valid = 0;
    @(posedge clk); model_clear();
    @(negedge clk); rst = 0;
    cyc(pool[0], 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(32'h9000, 0, 0, 0, 0, 0, 0, 0, "R1");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule